// File: doc/BRIEF.md
# Virtual-Channel Router Input Stage

This block is the receiving side of one port of a virtual-channel router. Flits arrive from the upstream link with a virtual-channel number, a kind (head, body, tail or a single-flit packet), a destination coordinate and a payload. Each flit goes into a FIFO owned by the virtual channel it names. When a packet opens, the block works out the output port from the destination by dimension-order (X first, then Y) routing. It keeps that port in the channel's state, and every later flit of the packet follows it.

A flit waits a fixed number of pipeline cycles in the buffer and is then offered to the switch allocator. The allocator answers with a per-channel grant. The granted flit leaves toward the crossbar, and one credit for its channel goes back upstream. When the departing flit closes its packet, the credit also carries a flag saying the channel may be handed to a new packet, and the channel drops back to idle.

Top module: `vc_input_port`

## Requirements
- R1: During and right after reset, no channel is offered to the allocator (`sa_valid` all zero), no credit or departing flit is signalled, and every channel is idle (`vc_active` all zero).
- R2: A flit is stored only in a cycle where `in_valid` is high, and it goes into the FIFO of channel `in_vc`. With `in_valid` low, the other input fields have no effect.
- R3: For a head (kind 0) or single-flit (kind 3) flit, the output port is computed from the destination against the router's own position (`MY_X`, `MY_Y`). The encoding is 1 if dest X > own X, 2 if dest X < own X. Otherwise it is 3 if dest Y > own Y, 4 if dest Y < own Y, and 0 (local) when both are equal. The port is stored in the channel's state and shown on that channel's field of `sa_port`.
- R4: Body (kind 1) and tail (kind 2) flits ignore their destination fields and leave on the port stored by their packet's head.
- R5: A flit stored at clock edge k becomes eligible for allocation after edge k+LAT-1, with LAT the router latency parameter (default 2). It is not eligible before then.
- R6: Each channel holds up to DEPTH flits (default 4) and releases them in arrival order. Channels are independent of one another.
- R7: A grant bit for an eligible channel removes that channel's oldest flit at the next edge. In the following cycle, `sw_valid` is high and `sw_kind`, `sw_data` and `sw_port` describe that flit. If several eligible channels are granted, the lowest-numbered one wins.
- R8: A departing flit produces a credit: `credit_valid` is high and `credit_vc` names its channel, in the same cycle as `sw_valid`.
- R9: `credit_free` is high only with a credit whose flit was a tail (kind 2) or single-flit (kind 3).
- R10: A channel becomes active when a head or single-flit flit is stored in it. It returns to idle when a tail or single-flit flit leaves it.
- R11: A grant bit for a channel that is not eligible, because it is empty or its front flit is still being held, removes nothing and produces no credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Flit present on the upstream link |
| in_kind | input | 2 | Flit kind: 0 head, 1 body, 2 tail, 3 single-flit |
| in_vc | input | VCW | Virtual channel of the arriving flit |
| in_dest_x | input | CW | Destination X coordinate |
| in_dest_y | input | CW | Destination Y coordinate |
| in_data | input | DW | Flit payload |
| sa_grant | input | NUM_VC | Per-channel grant from the switch allocator |
| sa_valid | output | NUM_VC | Channel has an eligible flit at its front |
| sa_port | output | 3*NUM_VC | Stored output port per channel, 3 bits each |
| vc_active | output | NUM_VC | Channel is carrying a packet |
| sw_valid | output | 1 | A flit is leaving toward the crossbar |
| sw_kind | output | 2 | Kind of the leaving flit |
| sw_port | output | 3 | Output port of the leaving flit |
| sw_data | output | DW | Payload of the leaving flit |
| credit_valid | output | 1 | Credit returned upstream |
| credit_vc | output | VCW | Channel the credit belongs to |
| credit_free | output | 1 | Channel may be reallocated upstream |

## Verification
The hardest situation to reach is a grant that lands on a channel whose front flit has arrived but is still inside its hold window. From the ports, this looks like a ready channel being ignored. The bench creates it by raising the grant for a channel in the cycle right after a flit is stored there, then checks that no credit appears and that the flit is still offered and leaves on a later grant. A second case that is hard to see is a body flit whose own destination fields point somewhere else. The bench sends such a flit and checks that it still leaves on the port chosen by its head.

// File: rtl/vcin_pkg.sv
package vcin_pkg;

    typedef enum logic [1:0] {
        FK_HEAD = 2'd0,
        FK_BODY = 2'd1,
        FK_TAIL = 2'd2,
        FK_SOLO = 2'd3
    } flit_kind_e;

    typedef enum logic [2:0] {
        OP_LOCAL = 3'd0,
        OP_XPOS  = 3'd1,
        OP_XNEG  = 3'd2,
        OP_YPOS  = 3'd3,
        OP_YNEG  = 3'd4
    } out_port_e;

    typedef enum logic {
        VS_IDLE   = 1'b0,
        VS_ACTIVE = 1'b1
    } vc_state_e;

    localparam int PORT_W = 3;

    // A flit that starts a packet carries a fresh route.
    function automatic logic opens_packet(flit_kind_e k);
        return (k == FK_HEAD) || (k == FK_SOLO);
    endfunction

    // A flit that ends a packet releases its channel.
    function automatic logic closes_packet(flit_kind_e k);
        return (k == FK_TAIL) || (k == FK_SOLO);
    endfunction

endpackage

// File: rtl/vcin_route.sv
module vcin_route
    import vcin_pkg::*;
#(
    parameter int CW   = 2,
    parameter int MY_X = 1,
    parameter int MY_Y = 1
) (
    input  logic [CW-1:0] dest_x,
    input  logic [CW-1:0] dest_y,
    output out_port_e     port
);
    localparam logic [CW-1:0] OWN_X = CW'(MY_X);
    localparam logic [CW-1:0] OWN_Y = CW'(MY_Y);

    // X dimension resolved first, then Y, then local ejection.
    always_comb begin
        if (dest_x > OWN_X)      port = OP_XPOS;
        else if (dest_x < OWN_X) port = OP_XNEG;
        else if (dest_y > OWN_Y) port = OP_YPOS;
        else if (dest_y < OWN_Y) port = OP_YNEG;
        else                     port = OP_LOCAL;
    end
endmodule

// File: rtl/vcin_vc_buf.sv
module vcin_vc_buf
    import vcin_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    parameter int LAT   = 2,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1),
    localparam int HOLD = LAT - 1,
    localparam int HW   = (HOLD > 0) ? $clog2(HOLD + 1) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  flit_kind_e    wr_kind,
    input  logic [DW-1:0] wr_data,
    input  out_port_e     wr_route,
    input  logic          pop,
    output logic          ready,
    output flit_kind_e    front_kind,
    output logic [DW-1:0] front_data,
    output out_port_e     route,
    output vc_state_e     state
);
    flit_kind_e    kind_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [HW-1:0] hold_q [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CNTW-1:0] count;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign front_kind = kind_q[rd_ptr];
    assign front_data = data_q[rd_ptr];
    assign ready      = (count != '0) && (hold_q[rd_ptr] == '0);

    // Payload storage needs no reset; occupancy is tracked by count.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            kind_q[wr_ptr] <= wr_kind;
            data_q[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            route  <= OP_LOCAL;
            state  <= VS_IDLE;
            for (int i = 0; i < DEPTH; i++) hold_q[i] <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (pop)   rd_ptr <= bump(rd_ptr);
            count <= count + CNTW'(wr_en) - CNTW'(pop);

            // Each slot counts down its remaining pipeline hold.
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_en && (wr_ptr == AW'(i)))
                    hold_q[i] <= HW'(HOLD);
                else if (hold_q[i] != '0)
                    hold_q[i] <= hold_q[i] - 1'b1;
            end

            if (wr_en && opens_packet(wr_kind)) begin
                route <= wr_route;
                state <= VS_ACTIVE;
            end else if (pop && closes_packet(front_kind)) begin
                state <= VS_IDLE;
            end
        end
    end
endmodule

// File: rtl/vcin_depart.sv
module vcin_depart
    import vcin_pkg::*;
#(
    parameter int DW  = 16,
    parameter int VCW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop_any,
    input  logic [VCW-1:0]    pop_idx,
    input  flit_kind_e        kind,
    input  logic [DW-1:0]     data,
    input  out_port_e         port,
    output logic              credit_valid,
    output logic [VCW-1:0]    credit_vc,
    output logic              credit_free,
    output logic              sw_valid,
    output logic [1:0]        sw_kind,
    output logic [PORT_W-1:0] sw_port,
    output logic [DW-1:0]     sw_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            credit_valid <= 1'b0;
            credit_vc    <= '0;
            credit_free  <= 1'b0;
            sw_valid     <= 1'b0;
            sw_kind      <= '0;
            sw_port      <= '0;
            sw_data      <= '0;
        end else begin
            credit_valid <= pop_any;
            credit_vc    <= pop_idx;
            credit_free  <= pop_any && closes_packet(kind);
            sw_valid     <= pop_any;
            sw_kind      <= kind;
            sw_port      <= port;
            sw_data      <= data;
        end
    end
endmodule

// File: rtl/vc_input_port.sv
module vc_input_port
    import vcin_pkg::*;
#(
    parameter int NUM_VC = 4,
    parameter int DEPTH  = 4,
    parameter int DW     = 16,
    parameter int LAT    = 2,
    parameter int CW     = 2,
    parameter int MY_X   = 1,
    parameter int MY_Y   = 1,
    localparam int VCW   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [1:0]               in_kind,
    input  logic [VCW-1:0]           in_vc,
    input  logic [CW-1:0]            in_dest_x,
    input  logic [CW-1:0]            in_dest_y,
    input  logic [DW-1:0]            in_data,
    input  logic [NUM_VC-1:0]        sa_grant,
    output logic [NUM_VC-1:0]        sa_valid,
    output logic [PORT_W*NUM_VC-1:0] sa_port,
    output logic [NUM_VC-1:0]        vc_active,
    output logic                     sw_valid,
    output logic [1:0]               sw_kind,
    output logic [PORT_W-1:0]        sw_port,
    output logic [DW-1:0]            sw_data,
    output logic                     credit_valid,
    output logic [VCW-1:0]           credit_vc,
    output logic                     credit_free
);
    out_port_e     new_route;
    flit_kind_e    fk [NUM_VC];
    logic [DW-1:0] fd [NUM_VC];
    out_port_e     rt [NUM_VC];
    vc_state_e     st [NUM_VC];
    logic [NUM_VC-1:0] ready, pop_vec;
    logic              pop_any;
    logic [VCW-1:0]    pop_idx;

    vcin_route #(.CW(CW), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
        .dest_x (in_dest_x),
        .dest_y (in_dest_y),
        .port   (new_route)
    );

    // Grant resolution: lowest-numbered eligible granted channel wins.
    always_comb begin
        pop_vec = '0;
        pop_any = 1'b0;
        pop_idx = '0;
        for (int i = 0; i < NUM_VC; i++) begin
            if (!pop_any && sa_grant[i] && ready[i]) begin
                pop_vec[i] = 1'b1;
                pop_any    = 1'b1;
                pop_idx    = VCW'(i);
            end
        end
    end

    for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
        vcin_vc_buf #(.DEPTH(DEPTH), .DW(DW), .LAT(LAT)) u_buf (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (in_valid && (in_vc == VCW'(g))),
            .wr_kind    (flit_kind_e'(in_kind)),
            .wr_data    (in_data),
            .wr_route   (new_route),
            .pop        (pop_vec[g]),
            .ready      (ready[g]),
            .front_kind (fk[g]),
            .front_data (fd[g]),
            .route      (rt[g]),
            .state      (st[g])
        );
        assign sa_valid[g]                   = ready[g];
        assign sa_port[g*PORT_W +: PORT_W]   = rt[g];
        assign vc_active[g]                  = (st[g] == VS_ACTIVE);
    end

    vcin_depart #(.DW(DW), .VCW(VCW)) u_depart (
        .clk          (clk),
        .rst          (rst),
        .pop_any      (pop_any),
        .pop_idx      (pop_idx),
        .kind         (fk[pop_idx]),
        .data         (fd[pop_idx]),
        .port         (rt[pop_idx]),
        .credit_valid (credit_valid),
        .credit_vc    (credit_vc),
        .credit_free  (credit_free),
        .sw_valid     (sw_valid),
        .sw_kind      (sw_kind),
        .sw_port      (sw_port),
        .sw_data      (sw_data)
    );
endmodule

// File: rtl/vcin_checker.sv
module vcin_checker #(
    parameter int NUM_VC = 4,
    parameter int VCW    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        in_kind,
    input logic [VCW-1:0]    in_vc,
    input logic [NUM_VC-1:0] sa_grant,
    input logic [NUM_VC-1:0] sa_valid,
    input logic [NUM_VC-1:0] vc_active,
    input logic              sw_valid,
    input logic              credit_valid,
    input logic [VCW-1:0]    credit_vc,
    input logic              credit_free
);
    // R7 R8: an effective grant yields a departure and a credit next cycle.
    p_credit_after_pop_r8: assert property (@(posedge clk) disable iff (rst)
        (|(sa_grant & sa_valid)) |=> (credit_valid && sw_valid));

    // R11: no effective grant, no credit.
    p_no_stray_credit_r11: assert property (@(posedge clk) disable iff (rst)
        !(|(sa_grant & sa_valid)) |=> !credit_valid);

    // R9: the free flag never appears without a credit.
    p_free_with_credit_r9: assert property (@(posedge clk) disable iff (rst)
        credit_free |-> credit_valid);

    // R10: storing a packet opener activates its channel.
    p_head_activates_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_kind == 2'd0 || in_kind == 2'd3)) |=> vc_active[$past(in_vc)]);

    // R10: a freeing credit is seen with its channel already idle.
    p_free_means_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (credit_valid && credit_free) |-> !vc_active[credit_vc]);
endmodule

bind vc_input_port vcin_checker #(.NUM_VC(NUM_VC), .VCW(VCW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_kind      (in_kind),
    .in_vc        (in_vc),
    .sa_grant     (sa_grant),
    .sa_valid     (sa_valid),
    .vc_active    (vc_active),
    .sw_valid     (sw_valid),
    .credit_valid (credit_valid),
    .credit_vc    (credit_vc),
    .credit_free  (credit_free)
);

// File: tb/sim_vc_input_port.sv
module sim_vc_input_port;
    localparam int NUM_VC = 4;
    localparam int VCW    = 2;
    localparam int DW     = 16;
    localparam int CW     = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [1:0] in_kind = '0;
    logic [VCW-1:0] in_vc = '0;
    logic [CW-1:0] in_dest_x = '0, in_dest_y = '0;
    logic [DW-1:0] in_data = '0;
    logic [NUM_VC-1:0] sa_grant = '0;
    logic [NUM_VC-1:0] sa_valid, vc_active;
    logic [3*NUM_VC-1:0] sa_port;
    logic sw_valid, credit_valid, credit_free;
    logic [1:0] sw_kind;
    logic [2:0] sw_port;
    logic [DW-1:0] sw_data;
    logic [VCW-1:0] credit_vc;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vc_input_port #(.NUM_VC(NUM_VC), .DEPTH(4), .DW(DW), .LAT(2), .CW(CW),
                    .MY_X(1), .MY_Y(1)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
        .in_vc(in_vc), .in_dest_x(in_dest_x), .in_dest_y(in_dest_y),
        .in_data(in_data), .sa_grant(sa_grant), .sa_valid(sa_valid),
        .sa_port(sa_port), .vc_active(vc_active), .sw_valid(sw_valid),
        .sw_kind(sw_kind), .sw_port(sw_port), .sw_data(sw_data),
        .credit_valid(credit_valid), .credit_vc(credit_vc),
        .credit_free(credit_free)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // Starts and ends at a falling edge; the flit is stored at the edge between.
    task automatic send(int vc, int kind, int dx, int dy, int data);
        in_valid  = 1'b1;
        in_vc     = VCW'(vc);
        in_kind   = 2'(kind);
        in_dest_x = CW'(dx);
        in_dest_y = CW'(dy);
        in_data   = DW'(data);
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic grant(int vc);
        sa_grant = NUM_VC'(1) << vc;
        @(negedge clk);
        sa_grant = '0;
    endtask

    task automatic expect_depart(string req, int vc, int kind, int port, int data, bit free);
        chk({req, " sw_valid"}, 32'(sw_valid), 1);
        chk({req, " credit_valid"}, 32'(credit_valid), 1);
        chk({req, " credit_vc"}, 32'(credit_vc), 32'(vc));
        chk({req, " credit_free"}, 32'(credit_free), 32'(free));
        chk({req, " sw_kind"}, 32'(sw_kind), 32'(kind));
        chk({req, " sw_port"}, 32'(sw_port), 32'(port));
        chk({req, " sw_data"}, 32'(sw_data), 32'(data));
    endtask

    task automatic t_reset();
        chk("R1 sa_valid", 32'(sa_valid), 0);
        chk("R1 credit_valid", 32'(credit_valid), 0);
        chk("R1 sw_valid", 32'(sw_valid), 0);
        chk("R1 vc_active", 32'(vc_active), 0);
    endtask

    task automatic t_single();
        send(1, 3, 2, 1, 16'hA1);
        chk("R5 held one cycle", 32'(sa_valid[1]), 0);
        chk("R10 solo activates", 32'(vc_active[1]), 1);
        step();
        chk("R5 eligible", 32'(sa_valid), 32'h2);
        chk("R3 east", 32'(sa_port[3 +: 3]), 1);
        grant(1);
        expect_depart("R7 R8 R9 solo", 1, 3, 1, 16'hA1, 1);
        chk("R10 solo idle", 32'(vc_active[1]), 0);
        chk("R6 vc1 empty", 32'(sa_valid[1]), 0);
        step();
        chk("R8 credit one cycle", 32'(credit_valid), 0);
    endtask

    task automatic t_packet();
        send(2, 0, 0, 1, 16'hB0);
        send(2, 1, 3, 3, 16'hB1);
        send(2, 2, 1, 1, 16'hB2);
        chk("R3 west", 32'(sa_port[6 +: 3]), 2);
        chk("R4 route kept", 32'(sa_port[6 +: 3]), 2);
        grant(2);
        expect_depart("R9 head", 2, 0, 2, 16'hB0, 0);
        chk("R10 stays active", 32'(vc_active[2]), 1);
        grant(2);
        expect_depart("R4 body", 2, 1, 2, 16'hB1, 0);
        grant(2);
        expect_depart("R4 R9 tail", 2, 2, 2, 16'hB2, 1);
        chk("R10 tail idle", 32'(vc_active[2]), 0);
    endtask

    task automatic t_routes();
        int dx[4] = '{1, 1, 1, 0};
        int dy[4] = '{2, 0, 1, 0};
        int ep[4] = '{3, 4, 0, 2};
        for (int i = 0; i < 4; i++) begin
            send(0, 3, dx[i], dy[i], 16'hC0 + i);
            step();
            chk("R3 port", 32'(sa_port[2:0]), 32'(ep[i]));
            grant(0);
            expect_depart("R3 leave", 0, 3, ep[i], 16'hC0 + i, 1);
        end
    endtask

    task automatic t_ignored_grants();
        grant(3);
        chk("R11 empty credit", 32'(credit_valid), 0);
        chk("R11 empty sw", 32'(sw_valid), 0);
        send(3, 3, 2, 2, 16'hD3);
        grant(3);
        chk("R11 R5 held grant", 32'(credit_valid), 0);
        chk("R11 flit kept", 32'(sa_valid[3]), 1);
        grant(3);
        expect_depart("R11 later", 3, 3, 1, 16'hD3, 1);
    endtask

    task automatic t_invalid();
        in_kind = 2'd3; in_vc = 2'd1; in_data = 16'hEE; in_valid = 1'b0;
        step();
        step();
        chk("R2 no valid", 32'(sa_valid), 0);
        chk("R2 no activate", 32'(vc_active), 0);
    endtask

    task automatic t_fifo();
        for (int i = 0; i < 4; i++) send(0, 3, 1, 1, 16'h100 + i);
        step();
        for (int i = 0; i < 4; i++) begin
            grant(0);
            expect_depart("R6 order", 0, 3, 0, 16'h100 + i, 1);
        end
        chk("R6 drained", 32'(sa_valid[0]), 0);
    endtask

    task automatic t_two_vcs();
        send(0, 3, 2, 1, 16'h200);
        send(1, 3, 1, 2, 16'h201);
        chk("R2 both stored", 32'(sa_valid), 32'h1);
        step();
        chk("R2 both eligible", 32'(sa_valid), 32'h3);
        grant(1);
        expect_depart("R2 vc1", 1, 3, 3, 16'h201, 1);
        chk("R6 vc0 kept", 32'(sa_valid[0]), 1);
        sa_grant = 4'b0011;
        @(negedge clk);
        sa_grant = '0;
        expect_depart("R7 lowest", 0, 3, 1, 16'h200, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        step();
        t_reset();
        t_single();
        t_packet();
        t_routes();
        t_ignored_grants();
        t_invalid();
        t_fifo();
        t_two_vcs();
        step();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule